// File: doc/BRIEF.md
# Reset-Time Configuration Strap Latch with Shared LED Pads

This block captures a small set of board-level configuration straps while the device is held in hardware reset or in powerdown. It keeps them as the power-on defaults for the link-advertisement bits and for two power-control options. The strap pads are bidirectional. While the device is held, every pad is an input. Once the hold ends, the pads selected by a parameter mask turn into LED outputs. The remaining pads stay as inputs.

Two straps act on power control. The active-low clock-enable strap decides whether the system clock output keeps toggling while the device is held. The active-low low-power energy-detect strap makes the block raise an active-low wake interrupt when cable energy appears while the coma request is asserted.

The hold condition is `!rst_n || pwr_down`. It is sampled synchronously, so the hold must last for at least two clock edges. The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level signal that is sampled on the rising edge of `clk`.

The strap pads use these bit positions:

| Pad | Strap | Meaning |
|-----|-------|---------|
| 0 | speed | 1 means gigabit is advertised |
| 1 | pause | 1 means both pause bits are advertised |
| 2 | clock-enable | 0 means the clock runs while held |
| 3 | energy-detect | 0 means the wake mode is enabled |

Top module: `strap_led_ctrl`

## Requirements
- R1: On every rising edge where the hold is active, `strap_dflt` loads `pad_in`. After the hold ends, `strap_dflt` keeps the value taken at the last held edge, whatever `pad_in` does afterwards.
- R2: `pad_oe` is all zero while the hold is active and on the first rising edge after release. From the second rising edge after release, `pad_oe` equals `LED_MASK` (default: pads 0 and 1 shared).
- R3: `pad_out` equals `led_act & pad_oe`. A pad outside `LED_MASK` is never driven.
- R4: The advertisement vector `adv` has this layout: bit 0 is 10M, bit 1 is 100M, bit 2 is 1000M, bit 3 is symmetric pause and bit 4 is asymmetric pause. Its strap default is {pause, pause, speed, 1, 1}, so 10M and 100M are always advertised, 1000M follows pad 0 and both pause bits follow pad 1.
- R5: Outside the hold, `sw_wr` loads `sw_adv` into `adv` on the next edge. During the hold, `sw_wr` is ignored.
- R6: A new hold (reset or powerdown) reloads `adv` from the straps, discarding any software value.
- R7: While held, `sys_clk_out` toggles only if the latched clock-enable strap (pad 2) is 0. Outside the hold it always toggles.
- R8: Outside the hold, `mdint_n` goes low one edge after an edge where all of the following are true: `coma` is 1, the latched energy-detect strap (pad 3) is 0, `energy_det` is 1 and `irq_clr` is 0.
- R9: Once low, `mdint_n` stays low until an edge that sees `coma` at 0 or `irq_clr` at 1. A clear on the same edge as a set wins.
- R10: With the energy-detect strap at 1, or with `coma` at 0, or during the hold, `mdint_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset, sampled synchronously |
| pwr_down | input | 1 | Hardware powerdown, active high |
| coma | input | 1 | Coma (deep low-power) request |
| energy_det | input | 1 | Cable energy present |
| irq_clr | input | 1 | Pulse that clears the wake interrupt |
| pad_in | input | NPAD | Pad input levels |
| led_act | input | NPAD | LED drive values from the link logic |
| sw_wr | input | 1 | Software write strobe for the advertisement bits |
| sw_adv | input | 5 | Software advertisement value |
| strap_dflt | output | NPAD | Latched strap values |
| adv | output | 5 | Current advertisement bits |
| pad_oe | output | NPAD | Pad output enables |
| pad_out | output | NPAD | Pad output values |
| sys_clk_out | output | 1 | Gated system clock |
| mdint_n | output | 1 | Active-low wake interrupt |

## Verification
The bound assertions check on every cycle that the pads stay undriven through the hold and the release edge, and that no unmasked pad is driven. They also check that a software write lands on the next edge and that the release value of `adv` matches the strap default. Finally, they cover the set, hold and clear rules of the wake interrupt.

Only the bench scenarios can show the rest. These are the capture of each of the 16 strap patterns through both reset and powerdown, the immunity of the latched values to later pad activity, and the reload on a second hold. They also include whether the gated clock actually toggles under each clock-enable strap, which needs edge counting over a window.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STRAP_SPEED   = 0;
  localparam int STRAP_PAUSE   = 1;
  localparam int STRAP_CLKEN_N = 2;
  localparam int STRAP_LPED_N  = 3;
  localparam int NSTRAP        = 4;
  localparam int ADV_W         = 5;

  typedef struct packed {
    logic asym_pause;
    logic sym_pause;
    logic spd1000;
    logic spd100;
    logic spd10;
  } adv_t;

  function automatic adv_t adv_from_straps(input logic speed, input logic pause);
    adv_t a;
    a.asym_pause = pause;
    a.sym_pause  = pause;
    a.spd1000    = speed;
    a.spd100     = 1'b1;
    a.spd10      = 1'b1;
    return a;
  endfunction
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int NPAD = 4
) (
  input  logic             clk,
  input  logic             hold,
  input  logic [NPAD-1:0]  pad_in,
  input  logic             sw_wr,
  input  logic [ADV_W-1:0] sw_adv,
  output logic [NPAD-1:0]  strap_q,
  output logic [ADV_W-1:0] adv_q
);
  // Straps follow the pads on every held edge; the last held edge wins.
  always_ff @(posedge clk) begin
    if (hold) strap_q <= pad_in;
  end

  // Advertisement: strap default while held, software value afterwards.
  always_ff @(posedge clk) begin
    if (hold)
      adv_q <= adv_from_straps(pad_in[STRAP_SPEED], pad_in[STRAP_PAUSE]);
    else if (sw_wr)
      adv_q <= sw_adv;
  end
endmodule

// File: rtl/pad_dir_ctrl.sv
module pad_dir_ctrl #(
  parameter int            NPAD     = 4,
  parameter logic [NPAD-1:0] LED_MASK = 4'b0011
) (
  input  logic            clk,
  input  logic            hold,
  input  logic [NPAD-1:0] led_act,
  output logic [NPAD-1:0] pad_oe,
  output logic [NPAD-1:0] pad_out
);
  logic hold_d1;
  logic drive_ok;

  // drive_ok rises only after two unheld edges, so the pads keep one
  // spare cycle of input direction after the last strap sample.
  always_ff @(posedge clk) begin
    hold_d1  <= hold;
    drive_ok <= !hold && !hold_d1;
  end

  always_comb begin
    pad_oe  = (drive_ok && !hold) ? LED_MASK : '0;
    pad_out = led_act & pad_oe;
  end
endmodule

// File: rtl/sys_clk_gate.sv
module sys_clk_gate (
  input  logic clk,
  input  logic hold,
  input  logic clk_en_n_strap,
  output logic sys_clk_out
);
  logic run;
  logic en_lat;

  assign run = !hold || !clk_en_n_strap;

  // Enable changes only while clk is low, so the AND gate cannot glitch.
  always_ff @(negedge clk) begin
    en_lat <= run;
  end

  assign sys_clk_out = clk & en_lat;
endmodule

// File: rtl/wake_irq.sv
module wake_irq (
  input  logic clk,
  input  logic hold,
  input  logic coma,
  input  logic lped_en_n_strap,
  input  logic energy_det,
  input  logic irq_clr,
  output logic mdint_n
);
  logic irq_q;

  // Clear conditions take priority over the set condition.
  always_ff @(posedge clk) begin
    if (hold || !coma || irq_clr)
      irq_q <= 1'b0;
    else if (!lped_en_n_strap && energy_det)
      irq_q <= 1'b1;
  end

  assign mdint_n = !irq_q;
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_pkg::*;
#(
  parameter int              NPAD     = 4,
  parameter logic [NPAD-1:0] LED_MASK = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             coma,
  input  logic             energy_det,
  input  logic             irq_clr,
  input  logic [NPAD-1:0]  pad_in,
  input  logic [NPAD-1:0]  led_act,
  input  logic             sw_wr,
  input  logic [ADV_W-1:0] sw_adv,
  output logic [NPAD-1:0]  strap_dflt,
  output logic [ADV_W-1:0] adv,
  output logic [NPAD-1:0]  pad_oe,
  output logic [NPAD-1:0]  pad_out,
  output logic             sys_clk_out,
  output logic             mdint_n
);
  logic hold;
  assign hold = !rst_n || pwr_down;

  strap_sampler #(.NPAD(NPAD)) u_sampler (
    .clk     (clk),
    .hold    (hold),
    .pad_in  (pad_in),
    .sw_wr   (sw_wr),
    .sw_adv  (sw_adv),
    .strap_q (strap_dflt),
    .adv_q   (adv)
  );

  pad_dir_ctrl #(.NPAD(NPAD), .LED_MASK(LED_MASK)) u_pads (
    .clk     (clk),
    .hold    (hold),
    .led_act (led_act),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  sys_clk_gate u_clkgate (
    .clk            (clk),
    .hold           (hold),
    .clk_en_n_strap (strap_dflt[STRAP_CLKEN_N]),
    .sys_clk_out    (sys_clk_out)
  );

  wake_irq u_wake (
    .clk             (clk),
    .hold            (hold),
    .coma            (coma),
    .lped_en_n_strap (strap_dflt[STRAP_LPED_N]),
    .energy_det      (energy_det),
    .irq_clr         (irq_clr),
    .mdint_n         (mdint_n)
  );
endmodule

// File: rtl/strap_led_ctrl_chk.sv
module strap_led_ctrl_chk
  import strap_pkg::*;
#(
  parameter int              NPAD     = 4,
  parameter logic [NPAD-1:0] LED_MASK = 4'b0011
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             coma,
  input logic             energy_det,
  input logic             irq_clr,
  input logic             sw_wr,
  input logic [ADV_W-1:0] sw_adv,
  input logic [NPAD-1:0]  strap_dflt,
  input logic [ADV_W-1:0] adv,
  input logic [NPAD-1:0]  pad_oe,
  input logic [NPAD-1:0]  pad_out,
  input logic             mdint_n
);
  // R2: no drive during powerdown or on the first edge after any hold
  a_r2_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down || $past(pwr_down) || $past(!rst_n)) |-> (pad_oe == '0));

  // R3: only masked, enabled pads carry data
  a_r3_no_stray_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0) && ((pad_oe & ~LED_MASK) == '0));

  // R4: release value of adv is the strap-derived default
  a_r4_adv_default: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(pwr_down)) |->
      (adv == {strap_dflt[STRAP_PAUSE], strap_dflt[STRAP_PAUSE],
               strap_dflt[STRAP_SPEED], 2'b11}));

  // R5: an unheld software write lands on the next edge
  a_r5_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !pwr_down) |=> (adv == $past(sw_adv)));

  // R8: set condition produces the interrupt on the next edge
  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (coma && !strap_dflt[STRAP_LPED_N] && energy_det && !irq_clr && !pwr_down)
      |=> !mdint_n);

  // R9: interrupt stays low without a clear condition
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdint_n && coma && !irq_clr && !pwr_down) |=> !mdint_n);

  // R9: a clear pulse always releases the line
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> mdint_n);

  // R10: without coma there is no interrupt
  a_r10_no_coma: assert property (@(posedge clk) disable iff (!rst_n)
    !coma |=> mdint_n);
endmodule

bind strap_led_ctrl strap_led_ctrl_chk #(.NPAD(NPAD), .LED_MASK(LED_MASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_down   (pwr_down),
  .coma       (coma),
  .energy_det (energy_det),
  .irq_clr    (irq_clr),
  .sw_wr      (sw_wr),
  .sw_adv     (sw_adv),
  .strap_dflt (strap_dflt),
  .adv        (adv),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .mdint_n    (mdint_n)
);

// File: tb/strap_led_ctrl_tb.sv
`timescale 1ns/1ps
module strap_led_ctrl_tb;
  localparam int NPAD = 4;
  localparam logic [3:0] MASK = 4'b0011;

  logic clk = 1'b0;
  logic rst_n, pwr_down, coma, energy_det, irq_clr, sw_wr;
  logic [3:0] pad_in, led_act, strap_dflt, pad_oe, pad_out;
  logic [4:0] sw_adv, adv;
  logic sys_clk_out, mdint_n;

  int checks = 0;
  int fails  = 0;
  int clk_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge sys_clk_out) clk_cnt++;

  strap_led_ctrl #(.NPAD(NPAD), .LED_MASK(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .coma(coma),
    .energy_det(energy_det), .irq_clr(irq_clr), .pad_in(pad_in),
    .led_act(led_act), .sw_wr(sw_wr), .sw_adv(sw_adv),
    .strap_dflt(strap_dflt), .adv(adv), .pad_oe(pad_oe), .pad_out(pad_out),
    .sys_clk_out(sys_clk_out), .mdint_n(mdint_n)
  );

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] dflt_adv(input logic [3:0] p);
    return {p[1], p[1], p[0], 2'b11};
  endfunction

  task automatic set_hold(input bit use_pd, input bit on);
    if (use_pd) pwr_down = on; else rst_n = !on;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; pwr_down = 0; coma = 0; energy_det = 0; irq_clr = 0;
    sw_wr = 0; sw_adv = '0; pad_in = 4'hF; led_act = '0;
    step(3);
    chk("R2 reset oe", {4'h0, pad_oe}, 8'h00);
    chk("R10 reset irq", {7'h0, mdint_n}, 8'h01);
    rst_n = 1;
    step(2);

    for (int p = 0; p < 16; p++) begin
      bit pd;
      int c0;
      pd = p[0] ^ p[2];
      // Leave software-written adv in place to test the reload (R6).
      sw_adv = 5'b00100; sw_wr = 1; step(); sw_wr = 0;
      set_hold(pd, 1);
      pad_in = p[3:0];
      step(2);
      chk("R6 reload adv", {3'h0, adv}, {3'h0, dflt_adv(p[3:0])});
      chk("R1 held sample", {4'h0, strap_dflt}, {4'h0, p[3:0]});
      chk("R2 held oe", {4'h0, pad_oe}, 8'h00);
      sw_adv = 5'b01010; sw_wr = 1; step(); sw_wr = 0;
      chk("R5 write ignored in hold", {3'h0, adv}, {3'h0, dflt_adv(p[3:0])});
      c0 = clk_cnt; step(4);
      chk("R7 held clock", {7'h0, 1'(clk_cnt != c0)}, {7'h0, 1'(!p[2])});
      chk("R10 held irq", {7'h0, mdint_n}, 8'h01);

      set_hold(pd, 0);
      pad_in = ~p[3:0];
      led_act = 4'hF;
      step();
      chk("R2 release edge oe", {4'h0, pad_oe}, 8'h00);
      chk("R1 kept after release", {4'h0, strap_dflt}, {4'h0, p[3:0]});
      step();
      chk("R2 oe on", {4'h0, pad_oe}, {4'h0, MASK});
      chk("R4 adv default", {3'h0, adv}, {3'h0, dflt_adv(p[3:0])});
      chk("R3 led out", {4'h0, pad_out}, {4'h0, MASK});
      led_act = 4'(p ^ 4'hA); #1;
      chk("R3 led pattern", {4'h0, pad_out}, {4'h0, 4'(p ^ 4'hA) & MASK});
      c0 = clk_cnt; step(3);
      chk("R7 running clock", {7'h0, 1'(clk_cnt != c0)}, 8'h01);
      chk("R1 pads ignored", {4'h0, strap_dflt}, {4'h0, p[3:0]});

      sw_adv = 5'(p * 3 + 1); sw_wr = 1; step(); sw_wr = 0;
      chk("R5 sw write", {3'h0, adv}, {3'h0, 5'(p * 3 + 1)});

      // Wake interrupt
      energy_det = 1; step();
      chk("R10 no coma", {7'h0, mdint_n}, 8'h01);
      coma = 1; step();
      chk("R8 irq set", {7'h0, mdint_n}, {7'h0, p[3]});
      energy_det = 0; step(2);
      chk("R9 irq sticky", {7'h0, mdint_n}, {7'h0, p[3]});
      irq_clr = 1; step(); irq_clr = 0;
      chk("R9 clear pulse", {7'h0, mdint_n}, 8'h01);
      energy_det = 1; irq_clr = 1; step(); irq_clr = 0;
      chk("R9 clear wins", {7'h0, mdint_n}, 8'h01);
      step();
      chk("R8 irq reset", {7'h0, mdint_n}, {7'h0, p[3]});
      coma = 0; step();
      chk("R9 coma drop", {7'h0, mdint_n}, 8'h01);
      energy_det = 0;
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule